// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block is the part of a 16-bit processor core that moves control into and out of service routines. It watches for an external interrupt request, which carries a 3-bit urgency level and an 8-bit vector, and for two exception strobes: one for an undefined opcode and one for a privilege fault. When it accepts an event it saves the running context on the supervisor stack, looks up the handler's start address in a 256-word vector table based at address 0x0100, and passes that address to the core as the new program counter. It also carries out the return-from-interrupt operation, which restores the saved context from the stack.

The block owns the processor status word. Bit 15 is the mode bit (0 = supervisor, 1 = user), bits 10:8 hold the current urgency level and bits 2:0 hold the condition flags. It also holds a saved copy of the supervisor stack pointer and a saved copy of the user stack pointer. The live stack pointer sits in the core's register file: it arrives on `sp_cur`, and the block writes it back with `sp_load`/`sp_new`. The core keeps fetch stalled while `busy` is high and reloads its program counter when `pc_load` pulses. The memory port returns read data one cycle after the read request.

Top module: `trap_seq`

## Requirements
- R1: An interrupt is accepted only in a cycle with `irq_req` and `insn_done` both high, `irq_prio` strictly greater than status bits 10:8, no exception strobe, no return request and `busy` low. `busy` rises in the following cycle.
- R2: An exception strobe is accepted in any cycle with `busy` low, whatever the level of `insn_done`. It wins over an interrupt in the same cycle. A privilege fault uses vector 0x00 and an undefined opcode uses vector 0x01.
- R3: On entry, status bit 15 is cleared. An interrupt writes `irq_prio` into bits 10:8. An exception leaves bits 10:8 as they were. All other bits are kept.
- R4: On entry from user mode, the value of `sp_cur` is saved as the user copy and the saved supervisor copy becomes the working stack pointer. On entry from supervisor mode, `sp_cur` is used as it is.
- R5: Entry writes the old status word to address SP-1 and then the old PC (`pc_cur` in the accept cycle) to address SP-2. It then returns SP-2 on `sp_new` with `sp_load`.
- R6: Entry reads the word at 0x0100 plus the vector and presents it on `pc_new`, with `pc_load` high exactly 4 cycles after the accept cycle.
- R7: A return request in supervisor mode reads the PC from address SP and the status word from SP+1. It pulses `pc_load` with the popped PC exactly 3 cycles after acceptance and restores all 16 status bits.
- R8: After a return, `sp_new` is SP+2 if the restored mode is supervisor. If the restored mode is user, `sp_new` is the saved user copy and SP+2 is kept as the supervisor copy.
- R9: A return request in user mode is handled as a privilege-fault entry (vector 0x00) and pops nothing.
- R10: `busy` is high from the cycle after acceptance through the `pc_load` cycle and low in the cycle after it. Requests and strobes seen while `busy` is high are ignored.
- R11: After reset the status word is 0x0000, `busy` is low, and no memory request, PC load or stack-pointer load is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_done | input | 1 | The current instruction ends in this cycle |
| irq_req | input | 1 | External interrupt request |
| irq_prio | input | 3 | Urgency level of the request |
| irq_vec | input | 8 | Vector of the request |
| exc_illegal | input | 1 | Undefined-opcode exception strobe |
| exc_priv | input | 1 | Privilege-fault exception strobe |
| rti_req | input | 1 | Return-from-interrupt request |
| pc_cur | input | 16 | PC of the interrupted program |
| sp_cur | input | 16 | Current stack-pointer register value |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| pc_load | output | 1 | One-cycle pulse: load `pc_new` into the PC |
| pc_new | output | 16 | New PC value |
| sp_load | output | 1 | One-cycle pulse: load `sp_new` into the stack-pointer register |
| sp_new | output | 16 | New stack-pointer value |
| psr | output | 16 | Processor status word |
| busy | output | 1 | Sequence in progress; stalls fetch |

## Verification
A table of interrupts is taken from supervisor mode at level zero and each is followed by a return. It covers levels 0 to 7 and vectors 0x00, 0x80, 0x81 and 0xFF, so a level that is not strictly higher is told apart from one that is, and the table address at both ends of its range is checked. Directed cases check nested interrupts at equal and higher levels, an interrupt without an instruction boundary, and an exception raised together with an interrupt, which shows whether the level is kept or raised. A trip into user mode and back through the undefined-opcode, privilege-fault and interrupt paths shows whether the two saved stack pointers are exchanged correctly in both directions.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_SR,
        S_PUSH_PC,
        S_VEC_RD,
        S_VEC_END,
        S_POP_PC,
        S_POP_SR,
        S_RET_END
    } seq_state_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
    parameter int PRIO_W   = 3,
    parameter int VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_PRIV = '0,
    parameter logic [VEC_W-1:0] VEC_ILL  = VEC_W'(1)
) (
    input  logic              idle,
    input  logic              insn_done,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              exc_illegal,
    input  logic              exc_priv,
    input  logic              rti_req,
    input  logic              cur_user,
    input  logic [PRIO_W-1:0] cur_prio,
    output logic              take_entry,
    output logic              take_ret,
    output logic              entry_is_irq,
    output logic [VEC_W-1:0]  entry_vec
);
    logic priv_fault;
    logic exc_any;
    logic irq_ok;

    always_comb begin
        // a return attempt from user mode is itself a privilege fault
        priv_fault   = exc_priv | (rti_req & cur_user);
        exc_any      = priv_fault | exc_illegal;
        irq_ok       = irq_req & insn_done & ~rti_req & (irq_prio > cur_prio);
        take_entry   = idle & (exc_any | irq_ok);
        take_ret     = idle & rti_req & ~cur_user & ~exc_illegal & ~exc_priv;
        entry_is_irq = ~exc_any;
        if (priv_fault)       entry_vec = VEC_PRIV;
        else if (exc_illegal) entry_vec = VEC_ILL;
        else                  entry_vec = irq_vec;
    end
endmodule

// File: rtl/trap_sp_sel.sv
module trap_sp_sel #(
    parameter int DW = 16
) (
    input  logic          cur_user,
    input  logic          new_user,
    input  logic [DW-1:0] sp_reg,
    input  logic [DW-1:0] sp_work,
    input  logic [DW-1:0] ssp_q,
    input  logic [DW-1:0] usp_q,
    output logic [DW-1:0] ent_sp,
    output logic [DW-1:0] ent_usp,
    output logic [DW-1:0] ret_sp,
    output logic [DW-1:0] ret_ssp
);
    always_comb begin
        // entry: leave user stack, switch to supervisor copy
        ent_sp  = cur_user ? ssp_q  : sp_reg;
        ent_usp = cur_user ? sp_reg : usp_q;
        // return: park supervisor pointer if going back to user mode
        ret_sp  = new_user ? usp_q   : sp_work;
        ret_ssp = new_user ? sp_work : ssp_q;
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq #(
    parameter int DW        = 16,
    parameter int VEC_W     = 8,
    parameter int PRIO_W    = 3,
    parameter int MODE_BIT  = 15,
    parameter int PRIO_LSB  = 8,
    parameter logic [DW-1:0] TABLE_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              exc_illegal,
    input  logic              exc_priv,
    input  logic              rti_req,
    input  logic [DW-1:0]     pc_cur,
    input  logic [DW-1:0]     sp_cur,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              pc_load,
    output logic [DW-1:0]     pc_new,
    output logic              sp_load,
    output logic [DW-1:0]     sp_new,
    output logic [DW-1:0]     psr,
    output logic              busy
);
    import trap_seq_pkg::*;

    localparam int PAD_W = DW - VEC_W;
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        seq_state_e     st;
        logic [DW-1:0]  psr;
        logic [DW-1:0]  sp;
        logic [DW-1:0]  ssp;
        logic [DW-1:0]  usp;
        logic [DW-1:0]  old_psr;
        logic [DW-1:0]  old_pc;
        logic [DW-1:0]  pc_pop;
        logic [VEC_W-1:0] vec;
    } regs_t;

    regs_t r_q, r_d;

    logic              take_entry, take_ret, entry_is_irq;
    logic [VEC_W-1:0]  entry_vec;
    logic [DW-1:0]     ent_sp, ent_usp, ret_sp, ret_ssp;

    trap_arbiter #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
        .idle        (r_q.st == S_IDLE),
        .insn_done   (insn_done),
        .irq_req     (irq_req),
        .irq_prio    (irq_prio),
        .irq_vec     (irq_vec),
        .exc_illegal (exc_illegal),
        .exc_priv    (exc_priv),
        .rti_req     (rti_req),
        .cur_user    (r_q.psr[MODE_BIT]),
        .cur_prio    (r_q.psr[PRIO_LSB +: PRIO_W]),
        .take_entry  (take_entry),
        .take_ret    (take_ret),
        .entry_is_irq(entry_is_irq),
        .entry_vec   (entry_vec)
    );

    trap_sp_sel #(.DW(DW)) u_sp (
        .cur_user(r_q.psr[MODE_BIT]),
        .new_user(mem_rdata[MODE_BIT]),
        .sp_reg  (sp_cur),
        .sp_work (r_q.sp),
        .ssp_q   (r_q.ssp),
        .usp_q   (r_q.usp),
        .ent_sp  (ent_sp),
        .ent_usp (ent_usp),
        .ret_sp  (ret_sp),
        .ret_ssp (ret_ssp)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.sp;
        mem_wdata = r_q.old_psr;
        pc_load   = 1'b0;
        pc_new    = r_q.pc_pop;
        sp_load   = 1'b0;
        sp_new    = r_q.sp;
        unique case (r_q.st)
            S_IDLE: begin
                if (take_entry) begin
                    r_d.old_psr         = r_q.psr;
                    r_d.old_pc          = pc_cur;
                    r_d.vec             = entry_vec;
                    r_d.psr[MODE_BIT]   = 1'b0;
                    if (entry_is_irq)
                        r_d.psr[PRIO_LSB +: PRIO_W] = irq_prio;
                    r_d.usp             = ent_usp;
                    r_d.sp              = ent_sp;
                    r_d.st              = S_PUSH_SR;
                end else if (take_ret) begin
                    r_d.sp = sp_cur;
                    r_d.st = S_POP_PC;
                end
            end
            S_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - ONE;
                mem_wdata = r_q.old_psr;
                r_d.sp    = r_q.sp - ONE;
                r_d.st    = S_PUSH_PC;
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - ONE;
                mem_wdata = r_q.old_pc;
                r_d.sp    = r_q.sp - ONE;
                r_d.st    = S_VEC_RD;
            end
            S_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = TABLE_BASE + {{PAD_W{1'b0}}, r_q.vec};
                r_d.st   = S_VEC_END;
            end
            S_VEC_END: begin
                pc_load = 1'b1;
                pc_new  = mem_rdata;
                sp_load = 1'b1;
                sp_new  = r_q.sp;
                r_d.st  = S_IDLE;
            end
            S_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
                r_d.sp   = r_q.sp + ONE;
                r_d.st   = S_POP_SR;
            end
            S_POP_SR: begin
                mem_req    = 1'b1;
                mem_addr   = r_q.sp;
                r_d.sp     = r_q.sp + ONE;
                r_d.pc_pop = mem_rdata;
                r_d.st     = S_RET_END;
            end
            S_RET_END: begin
                r_d.psr = mem_rdata;
                r_d.ssp = ret_ssp;
                pc_load = 1'b1;
                pc_new  = r_q.pc_pop;
                sp_load = 1'b1;
                sp_new  = ret_sp;
                r_d.st  = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign psr  = r_q.psr;
    assign busy = (r_q.st != S_IDLE);
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
    parameter int DW       = 16,
    parameter int VEC_W    = 8,
    parameter int PRIO_W   = 3,
    parameter int MODE_BIT = 15,
    parameter int PRIO_LSB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_done,
    input logic              irq_req,
    input logic [PRIO_W-1:0] irq_prio,
    input logic              exc_illegal,
    input logic              exc_priv,
    input logic              rti_req,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DW-1:0]     mem_addr,
    input logic              pc_load,
    input logic              sp_load,
    input logic [DW-1:0]     psr,
    input logic              busy
);
    p_low_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && (irq_prio <= psr[PRIO_LSB +: PRIO_W])
         && !exc_illegal && !exc_priv && !rti_req) |=> !busy);

    p_no_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !insn_done && !exc_illegal && !exc_priv && !rti_req) |=> !busy);

    p_exc_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (exc_illegal || exc_priv)) |=> busy);

    p_push_super_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !psr[MODE_BIT]);

    p_push_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (!(mem_req && mem_we) || (mem_addr == $past(mem_addr) - DW'(1))));

    p_sp_with_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |-> pc_load);

    p_load_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> busy);

    p_idle_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !pc_load));
endmodule

bind trap_seq trap_seq_chk #(
    .DW(DW), .VEC_W(VEC_W), .PRIO_W(PRIO_W), .MODE_BIT(MODE_BIT), .PRIO_LSB(PRIO_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
    .irq_prio(irq_prio), .exc_illegal(exc_illegal), .exc_priv(exc_priv),
    .rti_req(rti_req), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .pc_load(pc_load), .sp_load(sp_load), .psr(psr), .busy(busy)
);

// File: tb/trap_seq_bench.sv
`timescale 1ns/1ps
module trap_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0, irq_req = 1'b0, exc_illegal = 1'b0, exc_priv = 1'b0, rti_req = 1'b0;
    logic [2:0]  irq_prio = '0;
    logic [7:0]  irq_vec = '0;
    logic [15:0] pc_cur = '0, mem_rdata = '0;
    logic [15:0] r6 = 16'h3000;
    logic        mem_req, mem_we, pc_load, sp_load, busy;
    logic [15:0] mem_addr, mem_wdata, pc_new, sp_new, psr;

    logic        tb_we = 1'b0, r6_set = 1'b0;
    logic [15:0] tb_addr = '0, tb_data = '0, r6_val = '0;
    logic [15:0] mem [logic [15:0]];

    int nchk = 0, nfail = 0, lat = 0;
    logic [15:0] got_pc, got_sp;

    always #2 clk = ~clk;

    trap_seq u_trap_seq (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
        .irq_prio(irq_prio), .irq_vec(irq_vec), .exc_illegal(exc_illegal),
        .exc_priv(exc_priv), .rti_req(rti_req), .pc_cur(pc_cur), .sp_cur(r6),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load),
        .pc_new(pc_new), .sp_load(sp_load), .sp_new(sp_new), .psr(psr), .busy(busy)
    );

    function automatic logic [15:0] hnd(input logic [7:0] v);
        return 16'h4000 | {6'd0, v, 2'b00};
    endfunction

    function automatic logic [15:0] peek(input logic [15:0] a);
        if (a[15:8] == 8'h01) return hnd(a[7:0]);
        if (mem.exists(a)) return mem[a];
        return 16'hDEAD;
    endfunction

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= peek(mem_addr);
        if (mem_req && mem_we) mem[mem_addr] = mem_wdata;
        if (tb_we) mem[tb_addr] = tb_data;
        if (sp_load) r6 <= sp_new;
        else if (r6_set) r6 <= r6_val;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic set_r6(input logic [15:0] v);
        @(negedge clk); r6_set = 1'b1; r6_val = v;
        @(negedge clk); r6_set = 1'b0;
    endtask

    task automatic fire(input logic irq, input logic [2:0] p, input logic [7:0] v,
                        input logic ill, input logic prv, input logic rti,
                        input logic dn, input logic [15:0] pc);
        @(negedge clk);
        irq_req = irq; irq_prio = p; irq_vec = v; exc_illegal = ill;
        exc_priv = prv; rti_req = rti; insn_done = dn; pc_cur = pc;
        @(negedge clk);
        irq_req = 1'b0; exc_illegal = 1'b0; exc_priv = 1'b0; rti_req = 1'b0; insn_done = 1'b0;
    endtask

    task automatic wait_load();
        lat = 1;
        while (!pc_load && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        got_pc = pc_new;
        got_sp = sp_new;
    endtask

    task automatic entry_chk(input string req, input logic [15:0] sp0, input logic [15:0] exp_pc,
                             input logic [15:0] exp_sp, input logic [15:0] exp_psr,
                             input logic [15:0] push_sr, input logic [15:0] push_pc);
        wait_load();
        chk(req, "entry latency", lat, 4);
        chk(req, "handler pc", got_pc, exp_pc);
        chk(req, "entry sp", got_sp, exp_sp);
        @(negedge clk);
        chk(req, "entry status", psr, exp_psr);
        chk(req, "pushed status", peek(sp0 - 16'd1), push_sr);
        chk(req, "pushed pc", peek(sp0 - 16'd2), push_pc);
        chk(req, "idle after load", busy, 0);
    endtask

    task automatic ret_chk(input string req, input logic [15:0] exp_pc,
                           input logic [15:0] exp_sp, input logic [15:0] exp_psr);
        wait_load();
        chk(req, "return latency", lat, 3);
        chk(req, "return pc", got_pc, exp_pc);
        chk(req, "return sp", got_sp, exp_sp);
        @(negedge clk);
        chk(req, "restored status", psr, exp_psr);
    endtask

    task automatic no_take(input string req);
        for (int k = 0; k < 3; k++) begin
            chk(req, "stays idle", busy, 0);
            @(negedge clk);
        end
    endtask

    // {level, vector, interrupted pc}
    localparam logic [26:0] VTAB [5] = '{
        {3'd4, 8'h80, 16'h3010},
        {3'd7, 8'hFF, 16'h0400},
        {3'd1, 8'h81, 16'hBEEF},
        {3'd0, 8'h90, 16'h1111},
        {3'd2, 8'h00, 16'h2222}
    };

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "status", psr, 16'h0000);
        chk("R11", "busy", busy, 0);
        chk("R11", "mem_req", mem_req, 0);
        chk("R11", "pc_load", pc_load, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: interrupts from supervisor level 0, then return (R1 R3 R5 R6 R7 R8)
        for (int i = 0; i < 5; i++) begin
            logic [2:0]  p;
            logic [7:0]  v;
            logic [15:0] pc;
            {p, v, pc} = VTAB[i];
            fire(1'b1, p, v, 1'b0, 1'b0, 1'b0, 1'b1, pc);
            if (p == 3'd0) begin
                no_take("R1");
            end else begin
                chk("R1", "accepted", busy, 1);
                entry_chk("R6", 16'h3000, hnd(v), 16'h2FFE, {5'd0, p, 8'h00}, 16'h0000, pc);
                fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);
                ret_chk("R7", pc, 16'h3000, 16'h0000);
            end
        end

        // R1 nesting: equal level refused, higher level taken
        fire(1'b1, 3'd4, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0100);
        entry_chk("R3", 16'h3000, hnd(8'h80), 16'h2FFE, 16'h0400, 16'h0000, 16'h0100);
        fire(1'b1, 3'd4, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0200);
        no_take("R1");
        fire(1'b1, 3'd5, 8'h82, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0201);
        entry_chk("R1", 16'h2FFE, hnd(8'h82), 16'h2FFC, 16'h0500, 16'h0400, 16'h0201);
        fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);
        ret_chk("R7", 16'h0201, 16'h2FFE, 16'h0400);
        fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);
        ret_chk("R7", 16'h0100, 16'h3000, 16'h0000);

        // R1 no boundary: not taken
        fire(1'b1, 3'd6, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0300);
        no_take("R1");

        // R2 exception beats interrupt, level kept, no boundary needed
        fire(1'b1, 3'd7, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0310);
        entry_chk("R2", 16'h3000, hnd(8'h01), 16'h2FFE, 16'h0000, 16'h0000, 16'h0310);
        fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);
        ret_chk("R7", 16'h0310, 16'h3000, 16'h0000);

        // R10 strobe during busy ignored
        fire(1'b1, 3'd3, 8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0320);
        exc_illegal = 1'b1;
        wait_load();
        exc_illegal = 1'b0;
        chk("R10", "latency under strobe", lat, 4);
        chk("R10", "vector under strobe", got_pc, hnd(8'h44));
        @(negedge clk);
        chk("R10", "no re-entry", busy, 0);
        fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);
        ret_chk("R7", 16'h0320, 16'h3000, 16'h0000);

        // R8 return into user mode
        poke(16'h2FFE, 16'h1234);
        poke(16'h2FFF, 16'h8002);
        set_r6(16'h2FFE);
        fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0050);
        ret_chk("R8", 16'h1234, 16'h0000, 16'h8002);
        set_r6(16'h5000);

        // R4 exception from user mode swaps stacks
        fire(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1235);
        entry_chk("R4", 16'h3000, hnd(8'h01), 16'h2FFE, 16'h0002, 16'h8002, 16'h1235);
        fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);
        ret_chk("R8", 16'h1235, 16'h5000, 16'h8002);

        // R9 return attempted in user mode
        fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1236);
        entry_chk("R9", 16'h3000, hnd(8'h00), 16'h2FFE, 16'h0002, 16'h8002, 16'h1236);
        fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);
        ret_chk("R8", 16'h1236, 16'h5000, 16'h8002);

        // R3 interrupt from user mode raises level, clears mode bit
        fire(1'b1, 3'd4, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1237);
        entry_chk("R3", 16'h3000, hnd(8'h80), 16'h2FFE, 16'h0402, 16'h8002, 16'h1237);
        fire(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);
        ret_chk("R8", 16'h1237, 16'h5000, 16'h8002);
        chk("R4", "user stack live", r6, 16'h5000);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule